// File: doc/BRIEF.md
# Banked Program Address Mapper

This block sits beside a CPU that issues 16-bit program fetch addresses. It widens each fetch into an 18-bit physical address for a banked program ROM. The lower half of the logical space always lands in the fixed bank. The upper half lands in whichever bank a code-bank register selects. Bank 1 is only half as large as the other banks, so a fetch past its end is flagged as invalid.

A mode register picks one of two CPU modes. The block drives a flag that tells the call logic whether the bank register must be pushed as part of a subroutine call context. The block also holds the page number for the stack in data memory.

Interrupts are masked when the block leaves reset. The mask lifts only after software has written both system-controller registers, in either order. The control registers sit on a small synchronous register bus with a combinational read port.

Top module: `bank_mapper`

## Requirements
- R1: After reset, the following values hold. The mode is minimum, so `push_bank` is 0. The code bank reads 1. `stack_page` is 00H. `irq_masked` is 1.
- R2: A fetch address in 0000H..7FFFH appears unchanged on `phys_addr`, with bits 17..15 zero, and `bank_valid` is 1 whatever bank is selected.
- R3: A fetch address in 8000H..FFFFH with code bank b other than 1 gives `phys_addr` = b*8000H + (address - 8000H). Bits 17..15 carry b, and `bank_valid` is 1.
- R4: With code bank 1, fetches in 8000H..BFFFH map to physical 08000H..0BFFFH and are valid. Fetches in C000H..FFFFH drive `bank_valid` to 0.
- R5: A write to address FF00H stores bit 0 as the mode, where 0 is minimum and 1 is maximum. `push_bank` equals the stored mode from the cycle after the write.
- R6: A write to FF01H stores the 8-bit stack page. The page appears on `stack_page` from the cycle after the write and is otherwise held.
- R7: A write to FF02H stores bits 2..0 as the code bank, and every value 0..7 is accepted. Write-data bits 7..3 are discarded.
- R8: `irq_masked` falls in the cycle after the later of the writes to FF00H and FF01H, in either order. A write to only one of the two leaves it at 1. Once clear, it never rises without a reset.
- R9: `reg_rdata` follows `reg_addr` in the same cycle. FF00H returns {7'b0, mode}. FF01H returns the page. FF02H returns {5'b0, bank}. FF03H returns {7'b0, mask}. Any other address returns 00H, and a write to any other address changes nothing.
- R10: A reset that arrives after the mask has cleared sets it again. Both release writes are then needed once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_we | input | 1 | Register bus write strobe |
| reg_rdata | output | 8 | Register bus read data, combinational |
| fetch_addr | input | 16 | Logical program fetch address |
| phys_addr | output | 18 | Physical program ROM address |
| bank_valid | output | 1 | High when the fetch falls inside a real bank |
| push_bank | output | 1 | High when calls must push the bank register (maximum mode) |
| irq_masked | output | 1 | High while interrupts are held masked |
| stack_page | output | 8 | Data-memory page holding the stack |

## Verification
Each register reaches a port, either directly or through the read mux. A corrupted code bank therefore shows on `phys_addr` bits 17..15, or on `bank_valid` for the next fetch that falls in the upper half. A wrong mode shows on `push_bank` in the cycle after the write. The release tracking for the mask is the one piece of hidden state. An error there shows only as `irq_masked` falling one write too early, or not falling in the cycle after the second release write, so the bench probes it directly after each single write and after each pair.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    localparam int LA_W   = 16;
    localparam int PA_W   = 18;
    localparam int DW     = 8;
    localparam int BANK_W = PA_W - (LA_W - 1);
    localparam int OFS_W  = LA_W - 1;

    typedef enum logic {MODE_MIN = 1'b0, MODE_MAX = 1'b1} cpu_mode_e;

    localparam logic [LA_W-1:0] ADDR_MODE  = 16'hFF00;
    localparam logic [LA_W-1:0] ADDR_SPAGE = 16'hFF01;
    localparam logic [LA_W-1:0] ADDR_BANK  = 16'hFF02;
    localparam logic [LA_W-1:0] ADDR_MASK  = 16'hFF03;

    localparam logic [BANK_W-1:0] BANK_RESET = BANK_W'(1);
    localparam logic [BANK_W-1:0] SHORT_BANK = BANK_W'(1);

    typedef struct packed {
        cpu_mode_e          mode;
        logic [DW-1:0]      spage;
        logic [BANK_W-1:0]  bank;
        logic               masked;
    } ctrl_state_t;

    typedef struct packed {
        logic [PA_W-1:0] phys;
        logic            valid;
    } xlate_t;

    function automatic xlate_t map_fetch(input logic [LA_W-1:0] la,
                                         input logic [BANK_W-1:0] bank);
        xlate_t r;
        if (!la[LA_W-1]) begin
            r.phys  = {{BANK_W{1'b0}}, la[OFS_W-1:0]};
            r.valid = 1'b1;
        end else begin
            r.phys  = {bank, la[OFS_W-1:0]};
            // the short bank holds only the lower half of a full bank
            r.valid = !((bank == SHORT_BANK) && la[OFS_W-1]);
        end
        return r;
    endfunction
endpackage

// File: rtl/bm_ctrl_regs.sv
module bm_ctrl_regs
    import bankmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LA_W-1:0]  addr,
    input  logic [DW-1:0]    wdata,
    input  logic             we,
    output ctrl_state_t      state
);
    ctrl_state_t state_q;
    logic        seen_mode_q, seen_page_q;
    logic        wr_mode, wr_page, wr_bank;

    assign wr_mode = we && (addr == ADDR_MODE);
    assign wr_page = we && (addr == ADDR_SPAGE);
    assign wr_bank = we && (addr == ADDR_BANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.mode   <= MODE_MIN;
            state_q.spage  <= '0;
            state_q.bank   <= BANK_RESET;
            state_q.masked <= 1'b1;
            seen_mode_q    <= 1'b0;
            seen_page_q    <= 1'b0;
        end else begin
            if (wr_mode) state_q.mode  <= cpu_mode_e'(wdata[0]);
            if (wr_page) state_q.spage <= wdata;
            if (wr_bank) state_q.bank  <= wdata[BANK_W-1:0];
            seen_mode_q <= seen_mode_q | wr_mode;
            seen_page_q <= seen_page_q | wr_page;
            if ((seen_mode_q | wr_mode) && (seen_page_q | wr_page))
                state_q.masked <= 1'b0;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/bm_fetch_xlate.sv
module bm_fetch_xlate
    import bankmap_pkg::*;
(
    input  logic [LA_W-1:0]   fetch_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [PA_W-1:0]   phys_addr,
    output logic              bank_valid
);
    xlate_t res;

    always_comb res = map_fetch(fetch_addr, bank);

    assign phys_addr  = res.phys;
    assign bank_valid = res.valid;
endmodule

// File: rtl/bm_read_mux.sv
module bm_read_mux
    import bankmap_pkg::*;
(
    input  logic [LA_W-1:0] addr,
    input  ctrl_state_t     state,
    output logic [DW-1:0]   rdata
);
    always_comb begin
        unique case (addr)
            ADDR_MODE:  rdata = DW'(state.mode);
            ADDR_SPAGE: rdata = state.spage;
            ADDR_BANK:  rdata = DW'(state.bank);
            ADDR_MASK:  rdata = DW'(state.masked);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bankmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_we,
    output logic [7:0]       reg_rdata,
    input  logic [15:0]      fetch_addr,
    output logic [17:0]      phys_addr,
    output logic             bank_valid,
    output logic             push_bank,
    output logic             irq_masked,
    output logic [7:0]       stack_page
);
    ctrl_state_t       state;
    logic [BANK_W-1:0] cur_bank;

    bm_ctrl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .state (state)
    );

    bm_fetch_xlate u_xlate (
        .fetch_addr (fetch_addr),
        .bank       (state.bank),
        .phys_addr  (phys_addr),
        .bank_valid (bank_valid)
    );

    bm_read_mux u_rmux (
        .addr  (reg_addr),
        .state (state),
        .rdata (reg_rdata)
    );

    assign cur_bank   = state.bank;
    assign push_bank  = (state.mode == MODE_MAX);
    assign irq_masked = state.masked;
    assign stack_page = state.spage;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] reg_addr,
    input logic        reg_we,
    input logic [15:0] fetch_addr,
    input logic [17:0] phys_addr,
    input logic        bank_valid,
    input logic        push_bank,
    input logic        irq_masked,
    input logic [7:0]  stack_page,
    input logic [2:0]  cur_bank
);
    assert_reset_masks_R1: assert property (@(posedge clk)
        rst |=> irq_masked);

    assert_low_identity_R2: assert property (@(posedge clk) disable iff (rst)
        !fetch_addr[15] |-> (bank_valid && phys_addr == {2'b00, fetch_addr}));

    assert_invalid_only_short_R4: assert property (@(posedge clk) disable iff (rst)
        !bank_valid |-> (fetch_addr[15:14] == 2'b11 && cur_bank == 3'd1));

    assert_push_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_we && reg_addr == 16'hFF00)) |-> $stable(push_bank));

    assert_page_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_we && reg_addr == 16'hFF01)) |-> $stable(stack_page));

    assert_mask_no_rise_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$rose(irq_masked));
endmodule

bind bank_mapper bank_mapper_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .fetch_addr (fetch_addr),
    .phys_addr  (phys_addr),
    .bank_valid (bank_valid),
    .push_bank  (push_bank),
    .irq_masked (irq_masked),
    .stack_page (stack_page),
    .cur_bank   (cur_bank)
);

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reg_addr = 16'h0;
    logic [7:0]  reg_wdata = 8'h0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] fetch_addr = 16'h0;
    logic [17:0] phys_addr;
    logic        bank_valid, push_bank, irq_masked;
    logic [7:0]  stack_page;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    int m_bank = 1;
    int m_mode = 0;
    int m_page = 0;

    always #2 clk = ~clk;

    bank_mapper dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
        .phys_addr(phys_addr), .bank_valid(bank_valid), .push_bank(push_bank),
        .irq_masked(irq_masked), .stack_page(stack_page)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint exp_phys(input int la, input int bank);
        if (la < 'h8000) return la;
        return bank * 'h8000 + (la - 'h8000);
    endfunction

    function automatic bit exp_valid(input int la, input int bank);
        return !(la >= 'hC000 && bank == 1);
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 16'hFF00) m_mode = d[0];
        if (a == 16'hFF01) m_page = d;
        if (a == 16'hFF02) m_bank = d[2:0];
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic fetch(input string req, input int la);
        fetch_addr = la[15:0];
        #1;
        check({req, " valid"}, bank_valid, exp_valid(la, m_bank));
        if (exp_valid(la, m_bank))
            check({req, " phys"}, phys_addr, exp_phys(la, m_bank));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_bank = 1; m_mode = 0; m_page = 0;
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        fails++; checks++;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        do_reset();
        // R1 reset state
        check("R1 push_bank", push_bank, 0);
        check("R1 irq_masked", irq_masked, 1);
        check("R1 stack_page", stack_page, 0);
        rd("R1 bank read", 16'hFF02, 8'h01);
        // R2 low half, R4 short bank edges
        fetch("R2 low 0000", 'h0000);
        fetch("R2 low 7FFF", 'h7FFF);
        fetch("R4 bank1 8000", 'h8000);
        fetch("R4 bank1 BFFF", 'hBFFF);
        fetch("R4 bank1 C000", 'hC000);
        fetch("R4 bank1 FFFF", 'hFFFF);
        // R7 upper data bits ignored
        wr(16'hFF02, 8'hFD);
        rd("R7 bank masked", 16'hFF02, 8'h05);
        fetch("R3 bank5 FFFF", 'hFFFF);
        wr(16'hFF02, 8'h00);
        fetch("R3 bank0 9234", 'h9234);
        wr(16'hFF02, 8'h07);
        fetch("R3 bank7 C000", 'hC000);
        // R8 single write keeps mask; R5 mode
        wr(16'hFF01, 8'hA5);
        check("R6 page", stack_page, 8'hA5);
        check("R8 one write", irq_masked, 1);
        rd("R9 mask read", 16'hFF03, 8'h01);
        wr(16'hFF00, 8'hFF);
        check("R8 both writes", irq_masked, 0);
        check("R5 push max", push_bank, 1);
        rd("R9 mode read", 16'hFF00, 8'h01);
        rd("R9 page read", 16'hFF01, 8'hA5);
        rd("R9 mask clear read", 16'hFF03, 8'h00);
        // R9 other addresses
        wr(16'hFF04, 8'hFF);
        wr(16'h0F00, 8'h00);
        rd("R9 other read", 16'hFF04, 8'h00);
        check("R9 no side effect page", stack_page, 8'hA5);
        check("R9 no side effect push", push_bank, 1);
        rd("R9 bank kept", 16'hFF02, 8'h07);
        wr(16'hFF00, 8'h00);
        check("R5 push min", push_bank, 0);
        // R10 reset re-masks; other order of release writes
        do_reset();
        check("R10 remasked", irq_masked, 1);
        check("R10 push reset", push_bank, 0);
        wr(16'hFF00, 8'h01);
        check("R10 one write again", irq_masked, 1);
        wr(16'hFF00, 8'h00);
        check("R8 repeat same reg", irq_masked, 1);
        wr(16'hFF01, 8'h00);
        check("R8 reverse order", irq_masked, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 3);
            if (sel == 0) wr(16'hFF02, 8'($urandom));
            else if (sel == 1) wr(16'hFF00, 8'($urandom));
            else if (sel == 2) begin
                wr(16'hFF01, 8'($urandom));
                check("R6 random page", stack_page, m_page);
            end
            fetch("R3 random", int'($urandom_range(0, 16'hFFFF)));
            check("R5 random push", push_bank, m_mode);
            check("R8 stays clear", irq_masked, 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule